// File: doc/BRIEF.md
# PCI Target Claim Decoder

This block sits on the target side of a PCI-to-ISA bridge and decides, for every PCI transaction, whether the bridge claims it and on which clock it drives DEVSEL#. When it first sees FRAME# asserted, it takes a snapshot of the address, the command and IDSEL. It then runs that snapshot through a fixed set of decodes and a bank of programmable windows. The fixed decodes cover Type 0 configuration accesses to the bridge and the four DMA I/O ports. The bank holds eight I/O windows and four memory windows. Each window has its own DEVSEL# speed. If nothing claims the access by positive decode, the block claims it subtractively. It backs off if another agent has already answered.

The outputs are an active-low DEVSEL# strobe, a claim flag and a hit-source code. Together they tell the data-phase logic which decoder won. Window settings come in on plain configuration pins as flat vectors, with window n at slice n. Every pin is a plain level signal sampled on the rising clock edge. There is no valid/ready handshake: the block has no data stream and no back-pressure, because PCI timing is fixed by FRAME#, IRDY# and DEVSEL#.

The block only acts as a target. While the ISA side holds the bus-master input low, the bridge is a PCI master, and the decoder stays idle.

Top module: `pcitgt_claim`

## Requirements
- R1: After reset, devsel_n is 1, claim is 0 and hit_src is 0.
- R2: A decode starts at the rising edge where frame_n is sampled 0 and was sampled 1 at the previous edge, with the decoder idle. Address, command (cmd = ~cbe_n) and idsel are captured at that edge. Later values of ad have no effect on the transaction.
- R3: A command of 4'b1010 or 4'b1011 with idsel 1 and ad[1:0] = 2'b00 is a configuration hit. It gives hit_src 1 and medium timing.
- R4: An I/O command (4'b0010 or 4'b0011) whose full address equals 0x0, 0x4, 0xC0 or 0xC4 is a DMA port hit. It gives hit_src 2 and medium timing.
- R5: I/O window n hits on an I/O command when its enable bit is 1 and (ad & mask) == base. It gives hit_src 4+n. Its 2-bit speed code is 00 fast, 01 medium, 10 slow or 11 subtractive.
- R6: Memory window n hits in the same way on a memory command (4'b0110 or 4'b0111). It gives hit_src 12+n and uses its own speed code.
- R7: The decodes rank as follows: configuration, then DMA, then I/O windows (lowest index first), then memory windows (lowest index first), then the subtractive catch-all. The catch-all gives hit_src 3 with subtractive timing.
- R8: Fast, medium, slow and subtractive timing drive devsel_n low after the 1st, 2nd, 3rd and 4th edge following the start edge. With subtractive timing there is no claim if devsel_in_n is sampled 0 at any of edges 1 to 4.
- R9: If frame_n and irdy_n are both sampled 1 at or before the chosen edge, DEVSEL# is never asserted for that transaction.
- R10: A held claim ends, with devsel_n back to 1, after the first edge where frame_n and irdy_n are both sampled 1.
- R11: At any edge where isa_master_n is sampled 0, the decoder returns to idle. No claim starts, and a running or held claim is dropped.
- R12: claim is 1 exactly when devsel_n is 0. hit_src shows the winning source while claim is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| ad | input | AW | Address/data bus |
| cbe_n | input | 4 | Command / byte enables, active low |
| idsel | input | 1 | Configuration select for this device |
| devsel_in_n | input | 1 | Bus DEVSEL# as seen from other agents |
| isa_master_n | input | 1 | Low while the ISA side owns the bus as master |
| io_base | input | N_IO*AW | I/O window bases, window n at [n*AW +: AW] |
| io_mask | input | N_IO*AW | I/O window compare masks |
| io_en | input | N_IO | I/O window enables |
| io_spd | input | 2*N_IO | I/O window speed codes, window n at [2n +: 2] |
| mem_base | input | N_MEM*AW | Memory window bases |
| mem_mask | input | N_MEM*AW | Memory window compare masks |
| mem_en | input | N_MEM | Memory window enables |
| mem_spd | input | 2*N_MEM | Memory window speed codes |
| devsel_n | output | 1 | DEVSEL# drive, active low |
| claim | output | 1 | High while this device claims the transaction |
| hit_src | output | SRCW | Winning decode source |

## Verification
If the start edge is called A, devsel_n, claim and hit_src change only after edge A+1, A+2, A+3 or A+4 for the four speeds. A release or a master-mode drop shows up after the edge where its cause is sampled. The bench drives inputs on the falling edge and reads all three outputs on every falling edge of a transaction. Each read is compared with a value worked out from the speed, the competing DEVSEL# edge and the end edge, so a claim that comes one clock early or late fails on the cycle it happens. Random windows and addresses are compared against a priority model written in the bench.

// File: rtl/pcidec_pkg.sv
package pcidec_pkg;

  typedef enum logic [1:0] {
    SPD_FAST = 2'b00,
    SPD_MED  = 2'b01,
    SPD_SLOW = 2'b10,
    SPD_SUB  = 2'b11
  } spd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CLAIM
  } claim_st_e;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam int SRC_NONE = 0;
  localparam int SRC_CFG  = 1;
  localparam int SRC_DMA  = 2;
  localparam int SRC_SUB  = 3;
  localparam int SRC_IO0  = 4;

  // edge count after the start edge at which DEVSEL# goes low
  function automatic logic [2:0] spd_delay(spd_e s);
    case (s)
      SPD_FAST: spd_delay = 3'd1;
      SPD_MED:  spd_delay = 3'd2;
      SPD_SLOW: spd_delay = 3'd3;
      default:  spd_delay = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pcidec_fixed.sv
module pcidec_fixed
  import pcidec_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [3:0]    cmd,
  input  logic          idsel,
  output logic          cfg_hit,
  output logic          dma_hit
);

  logic is_cfg;
  logic is_io;

  assign is_cfg = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  assign is_io  = (cmd == CMD_IO_RD)  || (cmd == CMD_IO_WR);

  // type 0 only: low two address bits zero
  assign cfg_hit = is_cfg && idsel && (addr[1:0] == 2'b00);

  assign dma_hit = is_io && ((addr == AW'('h0))  || (addr == AW'('h4)) ||
                             (addr == AW'('hC0)) || (addr == AW'('hC4)));

endmodule

// File: rtl/pcidec_win_match.sv
module pcidec_win_match #(
  parameter int N  = 8,
  parameter int AW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0]   addr,
  input  logic            cmd_ok,
  input  logic [N*AW-1:0] base,
  input  logic [N*AW-1:0] mask,
  input  logic [N-1:0]    en,
  input  logic [2*N-1:0]  spd,
  output logic            hit,
  output logic [IW-1:0]   idx,
  output logic [1:0]      win_spd
);

  logic [N-1:0] hits;

  for (genvar g = 0; g < N; g++) begin : g_win
    assign hits[g] = cmd_ok && en[g] &&
                     ((addr & mask[g*AW +: AW]) == base[g*AW +: AW]);
  end

  // descending scan so the lowest matching index is written last
  always_comb begin
    hit     = |hits;
    idx     = '0;
    win_spd = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        idx     = IW'(i);
        win_spd = spd[2*i +: 2];
      end
    end
  end

  always_comb begin
    if (hit) begin
      a_r5_winner_enabled: assert (en[idx] && cmd_ok);
      for (int j = 0; j < N; j++) begin
        if (j < int'(idx)) begin
          a_r7_lowest_wins: assert (!hits[j]);
        end
      end
    end
  end

endmodule

// File: rtl/pcidec_claim_fsm.sv
module pcidec_claim_fsm
  import pcidec_pkg::*;
#(
  parameter int SRCW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            devsel_in_n,
  input  logic            isa_master_n,
  input  logic [SRCW-1:0] start_src,
  input  logic [2:0]      start_dly,
  input  logic            start_sub,
  output logic            devsel_n,
  output logic            claim,
  output logic [SRCW-1:0] hit_src
);

  claim_st_e       state;
  logic [2:0]      cnt;
  logic [2:0]      dly_q;
  logic            sub_q;
  logic            seen_q;
  logic [SRCW-1:0] src_q;
  logic            frame_q;
  logic            bus_end;

  assign bus_end = frame_n && irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      dly_q   <= '0;
      sub_q   <= 1'b0;
      seen_q  <= 1'b0;
      src_q   <= '0;
      frame_q <= 1'b1;
    end else begin
      frame_q <= frame_n;
      if (!isa_master_n) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (!frame_n && frame_q) begin
              state  <= ST_WAIT;
              cnt    <= 3'd1;
              dly_q  <= start_dly;
              sub_q  <= start_sub;
              src_q  <= start_src;
              seen_q <= 1'b0;
            end
          end
          ST_WAIT: begin
            if (bus_end) begin
              state <= ST_IDLE;
            end else if (cnt == dly_q) begin
              if (sub_q && (seen_q || !devsel_in_n)) state <= ST_IDLE;
              else                                   state <= ST_CLAIM;
            end else begin
              cnt <= cnt + 3'd1;
              if (!devsel_in_n) seen_q <= 1'b1;
            end
          end
          ST_CLAIM: begin
            if (bus_end) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign claim    = (state == ST_CLAIM);
  assign devsel_n = !claim;
  assign hit_src  = claim ? src_q : '0;

  a_r11_master_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !isa_master_n |=> devsel_n);

  a_r10_end_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_end |=> devsel_n);

  a_r8_sub_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && sub_q && !devsel_in_n) |=> devsel_n);

  a_r9_no_assert_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(!bus_end && isa_master_n));

  a_r12_source_shown: assert property (@(posedge clk) disable iff (!rst_n)
    !devsel_n |-> (hit_src != '0));

endmodule

// File: rtl/pcitgt_claim.sv
module pcitgt_claim
  import pcidec_pkg::*;
#(
  parameter int N_IO  = 8,
  parameter int N_MEM = 4,
  parameter int AW    = 32,
  localparam int SRCW = $clog2(SRC_IO0 + N_IO + N_MEM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic [AW-1:0]       ad,
  input  logic [3:0]          cbe_n,
  input  logic                idsel,
  input  logic                devsel_in_n,
  input  logic                isa_master_n,
  input  logic [N_IO*AW-1:0]  io_base,
  input  logic [N_IO*AW-1:0]  io_mask,
  input  logic [N_IO-1:0]     io_en,
  input  logic [2*N_IO-1:0]   io_spd,
  input  logic [N_MEM*AW-1:0] mem_base,
  input  logic [N_MEM*AW-1:0] mem_mask,
  input  logic [N_MEM-1:0]    mem_en,
  input  logic [2*N_MEM-1:0]  mem_spd,
  output logic                devsel_n,
  output logic                claim,
  output logic [SRCW-1:0]     hit_src
);

  localparam int IO_IW  = (N_IO  > 1) ? $clog2(N_IO)  : 1;
  localparam int MEM_IW = (N_MEM > 1) ? $clog2(N_MEM) : 1;

  logic [3:0]        cmd;
  logic              io_cmd;
  logic              mem_cmd;
  logic              cfg_hit;
  logic              dma_hit;
  logic              io_hit;
  logic              mem_hit;
  logic [IO_IW-1:0]  io_idx;
  logic [MEM_IW-1:0] mem_idx;
  logic [1:0]        io_wspd;
  logic [1:0]        mem_wspd;
  logic [SRCW-1:0]   dec_src;
  spd_e              dec_spd;
  logic [2:0]        dec_dly;
  logic              dec_sub;

  assign cmd     = ~cbe_n;
  assign io_cmd  = (cmd == CMD_IO_RD)  || (cmd == CMD_IO_WR);
  assign mem_cmd = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);

  pcidec_fixed #(.AW(AW)) u_fixed (
    .addr    (ad),
    .cmd     (cmd),
    .idsel   (idsel),
    .cfg_hit (cfg_hit),
    .dma_hit (dma_hit)
  );

  pcidec_win_match #(.N(N_IO), .AW(AW)) u_io_win (
    .addr    (ad),
    .cmd_ok  (io_cmd),
    .base    (io_base),
    .mask    (io_mask),
    .en      (io_en),
    .spd     (io_spd),
    .hit     (io_hit),
    .idx     (io_idx),
    .win_spd (io_wspd)
  );

  pcidec_win_match #(.N(N_MEM), .AW(AW)) u_mem_win (
    .addr    (ad),
    .cmd_ok  (mem_cmd),
    .base    (mem_base),
    .mask    (mem_mask),
    .en      (mem_en),
    .spd     (mem_spd),
    .hit     (mem_hit),
    .idx     (mem_idx),
    .win_spd (mem_wspd)
  );

  // fixed ranking of decode sources
  always_comb begin
    if (cfg_hit) begin
      dec_src = SRCW'(SRC_CFG);
      dec_spd = SPD_MED;
    end else if (dma_hit) begin
      dec_src = SRCW'(SRC_DMA);
      dec_spd = SPD_MED;
    end else if (io_hit) begin
      dec_src = SRCW'(SRC_IO0 + int'(io_idx));
      dec_spd = spd_e'(io_wspd);
    end else if (mem_hit) begin
      dec_src = SRCW'(SRC_IO0 + N_IO + int'(mem_idx));
      dec_spd = spd_e'(mem_wspd);
    end else begin
      dec_src = SRCW'(SRC_SUB);
      dec_spd = SPD_SUB;
    end
  end

  assign dec_dly = spd_delay(dec_spd);
  assign dec_sub = (dec_spd == SPD_SUB);

  pcidec_claim_fsm #(.SRCW(SRCW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_n      (frame_n),
    .irdy_n       (irdy_n),
    .devsel_in_n  (devsel_in_n),
    .isa_master_n (isa_master_n),
    .start_src    (dec_src),
    .start_dly    (dec_dly),
    .start_sub    (dec_sub),
    .devsel_n     (devsel_n),
    .claim        (claim),
    .hit_src      (hit_src)
  );

  always_comb begin
    a_r7_fixed_over_windows: assert (!(cfg_hit && dma_hit));
  end

endmodule

// File: tb/pcitgt_claim_bench.sv
module pcitgt_claim_bench;

  localparam int NI = 8;
  localparam int NM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1;
  logic irdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0] cbe_n = 4'hF;
  logic idsel = 1'b0;
  logic devsel_in_n = 1'b1;
  logic isa_master_n = 1'b1;
  logic [NI*32-1:0] io_base, io_mask;
  logic [NI-1:0] io_en;
  logic [2*NI-1:0] io_spd;
  logic [NM*32-1:0] mem_base, mem_mask;
  logic [NM-1:0] mem_en;
  logic [2*NM-1:0] mem_spd;
  logic devsel_n, claim;
  logic [3:0] hit_src;

  logic [31:0] iob [NI];
  logic [31:0] iom [NI];
  logic        ioe [NI];
  logic [1:0]  ios [NI];
  logic [31:0] mb  [NM];
  logic [31:0] mm  [NM];
  logic        me  [NM];
  logic [1:0]  ms  [NM];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NI; i++) begin
      io_base[i*32 +: 32] = iob[i];
      io_mask[i*32 +: 32] = iom[i];
      io_en[i]            = ioe[i];
      io_spd[2*i +: 2]    = ios[i];
    end
    for (int i = 0; i < NM; i++) begin
      mem_base[i*32 +: 32] = mb[i];
      mem_mask[i*32 +: 32] = mm[i];
      mem_en[i]            = me[i];
      mem_spd[2*i +: 2]    = ms[i];
    end
  end

  pcitgt_claim u_pcitgt_claim (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
    .cbe_n(cbe_n), .idsel(idsel), .devsel_in_n(devsel_in_n),
    .isa_master_n(isa_master_n), .io_base(io_base), .io_mask(io_mask),
    .io_en(io_en), .io_spd(io_spd), .mem_base(mem_base), .mem_mask(mem_mask),
    .mem_en(mem_en), .mem_spd(mem_spd), .devsel_n(devsel_n), .claim(claim),
    .hit_src(hit_src)
  );

  // expected decode from the requirement text
  function automatic void model(input logic [3:0] cmd, input logic [31:0] a,
                                input logic sel, output int src,
                                output int dly, output bit sub);
    bit io  = (cmd == 4'b0010) || (cmd == 4'b0011);
    bit mem = (cmd == 4'b0110) || (cmd == 4'b0111);
    int code = 3;
    src = -1;
    if ((cmd == 4'b1010 || cmd == 4'b1011) && sel && a[1:0] == 2'b00) begin
      src = 1; code = 1;
    end else if (io && (a == 32'h0 || a == 32'h4 || a == 32'hC0 || a == 32'hC4)) begin
      src = 2; code = 1;
    end
    if (src < 0 && io)
      for (int i = 0; i < NI; i++)
        if (src < 0 && ioe[i] && ((a & iom[i]) == iob[i])) begin
          src = 4 + i; code = int'(ios[i]);
        end
    if (src < 0 && mem)
      for (int i = 0; i < NM; i++)
        if (src < 0 && me[i] && ((a & mm[i]) == mb[i])) begin
          src = 12 + i; code = int'(ms[i]);
        end
    if (src < 0) begin
      src = 3; code = 3;
    end
    dly = code + 1;
    sub = (code == 3);
  endfunction

  task automatic check_out(input string tag, input bit exp_cl, input int exp_src);
    int es = exp_cl ? exp_src : 0;
    checks++;
    if (devsel_n !== !exp_cl || claim !== exp_cl || hit_src !== 4'(es)) begin
      errors++;
      $display("FAIL %s (R12) devsel_n=%0b claim=%0b hit_src=%0d expected devsel_n=%0b claim=%0b hit_src=%0d",
               tag, devsel_n, claim, hit_src, !exp_cl, exp_cl, es);
    end
  endtask

  // other_k: first edge with bus DEVSEL# low (0 none); end_k: end edge (0 none)
  task automatic txn(input string tag, input logic [3:0] cmd, input logic [31:0] a,
                     input logic sel, input int other_k, input int end_k);
    int src, dly;
    bit sub, ok;
    model(cmd, a, sel, src, dly, sub);
    ok = !(sub && other_k != 0 && other_k <= dly) && !(end_k != 0 && end_k <= dly);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = ~cmd; idsel = sel; devsel_in_n = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 6; k++) begin
      bit ended = (end_k != 0 && k >= end_k);
      frame_n = ended; irdy_n = ended;
      devsel_in_n = !(other_k != 0 && k >= other_k);
      ad = $urandom; idsel = 1'b0;
      @(negedge clk);
      check_out(tag, ok && k >= dly && !ended, src);
    end
    frame_n = 1'b1; irdy_n = 1'b1; devsel_in_n = 1'b1;
    @(negedge clk);
    check_out({tag, " R10 release"}, 1'b0, 0);
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NI; i++) begin iob[i] = 32'hFFFF_FFFF; iom[i] = '0; ioe[i] = 0; ios[i] = 0; end
    for (int i = 0; i < NM; i++) begin mb[i] = 32'hFFFF_FFFF; mm[i] = '0; me[i] = 0; ms[i] = 0; end
  endtask

  initial begin
    void'($urandom(32'd4711));
    clear_cfg();
    iob[0] = 32'h300; iom[0] = 32'hFFFF_FFF0; ioe[0] = 1; ios[0] = 2'b00;
    iob[1] = 32'h300; iom[1] = 32'hFFFF_FF00; ioe[1] = 1; ios[1] = 2'b01;
    iob[2] = 32'h400; iom[2] = 32'hFFFF_FF00; ioe[2] = 1; ios[2] = 2'b10;
    iob[3] = 32'h500; iom[3] = 32'hFFFF_FF00; ioe[3] = 1; ios[3] = 2'b11;
    iob[4] = 32'hC0;  iom[4] = 32'hFFFF_FFF0; ioe[4] = 1; ios[4] = 2'b00;
    iob[5] = 32'h600; iom[5] = 32'hFFFF_FF00; ioe[5] = 0; ios[5] = 2'b00;
    mb[0] = 32'hF000_0000; mm[0] = 32'hF000_0000; me[0] = 1; ms[0] = 2'b01;
    mb[1] = 32'hE000_0000; mm[1] = 32'hFFFF_0000; me[1] = 0; ms[1] = 2'b00;
    mb[2] = 32'hE000_0000; mm[2] = 32'hFFFF_0000; me[2] = 1; ms[2] = 2'b00;
    mb[3] = 32'hD000_0000; mm[3] = 32'hFF00_0000; me[3] = 1; ms[3] = 2'b10;
    repeat (3) @(negedge clk);
    check_out("R1 reset", 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after reset", 1'b0, 0);

    txn("R3 cfg type0", 4'b1010, 32'h0000_0010, 1'b1, 0, 0);
    txn("R3 cfg no idsel", 4'b1011, 32'h0000_0010, 1'b0, 0, 0);
    txn("R3 cfg type1", 4'b1010, 32'h0000_0011, 1'b1, 0, 0);
    txn("R4 dma C4", 4'b0011, 32'hC4, 1'b0, 0, 0);
    txn("R4 dma 0", 4'b0010, 32'h0, 1'b0, 2, 0);
    txn("R4 not dma 8", 4'b0010, 32'h8, 1'b0, 0, 0);
    txn("R7 dma over win4", 4'b0010, 32'hC0, 1'b0, 0, 0);
    txn("R7 win4 non-dma", 4'b0010, 32'hC8, 1'b0, 0, 0);
    txn("R7 overlap low wins", 4'b0010, 32'h305, 1'b0, 0, 0);
    txn("R5 win1 medium", 4'b0011, 32'h3A0, 1'b0, 0, 0);
    txn("R5 win2 slow", 4'b0010, 32'h412, 1'b0, 0, 0);
    txn("R5 win3 subtractive", 4'b0010, 32'h577, 1'b0, 0, 0);
    txn("R5 disabled win5", 4'b0010, 32'h610, 1'b0, 0, 0);
    txn("R5 io cmd on mem window", 4'b0010, 32'hF000_0000, 1'b0, 0, 0);
    txn("R6 mem win0", 4'b0110, 32'hF123_4560, 1'b0, 0, 0);
    txn("R6 mem win2 fast", 4'b0111, 32'hE000_1234, 1'b0, 0, 0);
    txn("R6 mem win3 slow", 4'b0110, 32'hD0AB_0000, 1'b0, 0, 0);
    txn("R6 mem cmd on io window", 4'b0110, 32'h305, 1'b0, 0, 0);
    txn("R8 sub free", 4'b0000, 32'h1234, 1'b0, 0, 0);
    txn("R8 sub other at 4", 4'b0010, 32'h9000, 1'b0, 4, 0);
    txn("R8 sub other at 1", 4'b0110, 32'h1000_0000, 1'b0, 1, 0);
    txn("R8 sub other at 5", 4'b0010, 32'h9000, 1'b0, 5, 0);
    txn("R8 positive ignores other", 4'b0010, 32'h301, 1'b0, 1, 0);
    txn("R9 slow end at 3", 4'b0010, 32'h412, 1'b0, 0, 3);
    txn("R9 medium end at 1", 4'b0110, 32'hF000_0000, 1'b0, 0, 1);
    txn("R10 fast end at 3", 4'b0010, 32'h301, 1'b0, 0, 3);

    // R11: master mode blocks a start
    @(negedge clk);
    isa_master_n = 1'b0;
    frame_n = 1'b0; ad = 32'h301; cbe_n = ~4'b0010;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_out("R11 master blocks start", 1'b0, 0);
    end
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    isa_master_n = 1'b1;
    // R11: master mode drops a held claim
    @(negedge clk);
    frame_n = 1'b0; ad = 32'h301; cbe_n = ~4'b0010;
    @(negedge clk);
    ad = $urandom;
    @(negedge clk);
    check_out("R11 claim before drop", 1'b1, 4);
    isa_master_n = 1'b0;
    @(negedge clk);
    check_out("R11 claim dropped", 1'b0, 0);
    isa_master_n = 1'b1;
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // R2: random windows and accesses
    for (int t = 0; t < 300; t++) begin
      logic [3:0] cmds [8] = '{4'b0010, 4'b0011, 4'b0110, 4'b0111,
                               4'b1010, 4'b1011, 4'b0000, 4'b1100};
      logic [31:0] addr;
      int pick = int'($urandom % 4);
      if (t % 50 == 0) begin
        for (int i = 0; i < NI; i++) begin
          iom[i] = 32'hFFFF_FFFF << (4 + $urandom % 8);
          iob[i] = $urandom & iom[i]; ioe[i] = ($urandom % 4) != 0; ios[i] = 2'($urandom);
        end
        for (int i = 0; i < NM; i++) begin
          mm[i] = 32'hFFFF_FFFF << (16 + $urandom % 12);
          mb[i] = $urandom & mm[i]; me[i] = ($urandom % 4) != 0; ms[i] = 2'($urandom);
        end
      end
      case (pick)
        0: begin int w = int'($urandom % NI); addr = iob[w] | ($urandom & ~iom[w]); end
        1: begin int w = int'($urandom % NM); addr = mb[w] | ($urandom & ~mm[w]); end
        2: addr = 32'h0 | (($urandom % 2) ? 32'hC0 : 32'h0) | (($urandom % 2) ? 32'h4 : 32'h0);
        default: addr = $urandom;
      endcase
      txn("R2 random", cmds[$urandom % 8], addr, 1'($urandom),
          ($urandom % 3 == 0) ? int'(1 + $urandom % 6) : 0,
          ($urandom % 4 == 0) ? int'(1 + $urandom % 5) : 0);
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule